// File: doc/BRIEF.md
# Masked Chip-Select Area Decoder

The decoder splits a 32-bit bus address space into five programmable chip-select areas and one fallback area. Each programmable area has two 16-bit registers. The base register holds a pattern for address bits 31..16. The ignore register marks some of those bits as irrelevant. When an ignore bit is 0, the matching address bit must equal the base bit. When an ignore bit is 1, that address bit always matches. With no ignore bits set, an area covers one 64 KB block starting at `base << 16`. Each extra ignore bit doubles the area's reach.

Software programs the registers through a write-only port. That port has a register index, write data and a write strobe, and it is sampled on the rising clock edge. The address comparison and chip-select outputs are combinational on the incoming address. Several areas may match the same address. In that case the lowest-numbered area wins, so exactly one active-low select is driven while the address strobe is high. An address that no programmable area claims selects area 0.

Top module: `csdec_top`

## Requirements
- R1: After reset, base registers of areas 1 to 5 hold 0x0001 to 0x0005 (area k holds k), and all ignore registers hold 0x0000.
- R2: With ignore bits all 0, area k selects exactly the addresses whose bits 31..16 equal its base register. Address bits 15..0 never affect selection.
- R3: An ignore bit of 1 at position j makes address bit 16+j irrelevant for that area. An ignore bit of 0 requires equality at that bit.
- R4: When several programmable areas match, only the lowest-numbered one is selected.
- R5: When no programmable area matches and the address strobe is high, area 0 is selected (`cs_n[0]` low).
- R6: While `addr_vld` is low, every bit of `cs_n` is high.
- R7: While `addr_vld` is high, exactly one bit of `cs_n` is low. Bit k corresponds to area k.
- R8: Register index encoding for `wr_idx`: values 0..4 write the base register of areas 1..5, and values 8..12 write the ignore register of areas 1..5. A write changes behaviour only from the rising edge where `wr_en` is high. Before that edge the old value still applies.
- R9: Index values 5, 6, 7, 13, 14 and 15 are ignored: writing them changes no area's behaviour.
- R10: `cs_n` follows `addr` and `addr_vld` in the same cycle, with no clock delay.
- R11: `rst` is synchronous and active high. A reset asserted during operation restores the R1 values at the next rising edge, and it overrides a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index (see R8) |
| wr_data | input | 16 | Register write data |
| addr | input | 32 | Bus address |
| addr_vld | input | 1 | Address strobe, high while `addr` is valid |
| cs_n | output | 6 | Active-low chip selects; bit 0 is the fallback area |

## Verification
The bench builds the decoder with its default parameters: five areas, 16-bit tags, a 32-bit address and a 4-bit index. All ten index values that map to registers can therefore be reached, along with all six unused ones. Directed sequences cover the reset layout and single-bit boundary crossings around a 64 KB block. They also cover partly and fully ignored tags, stacked overlaps where a catch-all area sits behind narrower ones, and reset arriving together with a write. A random phase then mixes writes to any index with addresses drawn near the programmed bases, and the output is compared against a behavioural model on every clock.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
    localparam int AREAS  = 5;
    localparam int TAG_W  = 16;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 4;
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs #(
    parameter int N_AREA = 5,
    parameter int TAG_W  = 16,
    parameter int IDX_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [TAG_W-1:0]              wr_data,
    output logic [N_AREA-1:0][TAG_W-1:0]  base_q,
    output logic [N_AREA-1:0][TAG_W-1:0]  ign_q
);
    localparam int IGN_OFS = 2 ** (IDX_W - 1);

    typedef struct packed {
        logic [N_AREA-1:0][TAG_W-1:0] base;
        logic [N_AREA-1:0][TAG_W-1:0] ign;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (rst) begin
            for (int i = 0; i < N_AREA; i++) begin
                bank_d.base[i] = TAG_W'(i + 1);
                bank_d.ign[i]  = '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < N_AREA; i++) begin
                if (wr_idx == IDX_W'(i))           bank_d.base[i] = wr_data;
                if (wr_idx == IDX_W'(IGN_OFS + i)) bank_d.ign[i]  = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign base_q = bank_q.base;
    assign ign_q  = bank_q.ign;
endmodule

// File: rtl/csdec_match.sv
module csdec_match #(
    parameter int N_AREA = 5,
    parameter int TAG_W  = 16
) (
    input  logic [TAG_W-1:0]              tag,
    input  logic [N_AREA-1:0][TAG_W-1:0]  base_q,
    input  logic [N_AREA-1:0][TAG_W-1:0]  ign_q,
    output logic [N_AREA-1:0]             hit
);
    for (genvar g = 0; g < N_AREA; g++) begin : g_area
        assign hit[g] = ~|((tag ^ base_q[g]) & ~ign_q[g]);
    end
endmodule

// File: rtl/csdec_prio.sv
module csdec_prio #(
    parameter int N_AREA = 5
) (
    input  logic [N_AREA-1:0] hit,
    input  logic              addr_vld,
    output logic [N_AREA:0]   cs_n
);
    logic [N_AREA:0] grant;
    logic            taken;

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < N_AREA; i++) begin
            if (hit[i] && !taken) begin
                grant[i+1] = 1'b1;
                taken      = 1'b1;
            end
        end
        if (!taken) grant[0] = 1'b1;
        cs_n = addr_vld ? ~grant : '1;
    end
endmodule

// File: rtl/csdec_top.sv
module csdec_top #(
    parameter int N_AREA = csdec_pkg::AREAS,
    parameter int TAG_W  = csdec_pkg::TAG_W,
    parameter int ADDR_W = csdec_pkg::ADDR_W,
    parameter int IDX_W  = csdec_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_vld,
    output logic [N_AREA:0]   cs_n
);
    logic [N_AREA-1:0][TAG_W-1:0] base_q;
    logic [N_AREA-1:0][TAG_W-1:0] ign_q;
    logic [N_AREA-1:0]            hit;
    logic [TAG_W-1:0]             tag;

    assign tag = addr[ADDR_W-1 -: TAG_W];

    csdec_regs #(.N_AREA(N_AREA), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .base_q(base_q), .ign_q(ign_q)
    );

    csdec_match #(.N_AREA(N_AREA), .TAG_W(TAG_W)) i_match (
        .tag(tag), .base_q(base_q), .ign_q(ign_q), .hit(hit)
    );

    csdec_prio #(.N_AREA(N_AREA)) i_prio (
        .hit(hit), .addr_vld(addr_vld), .cs_n(cs_n)
    );
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
    parameter int N_AREA = 5,
    parameter int TAG_W  = 16,
    parameter int IDX_W  = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [IDX_W-1:0]              wr_idx,
    input logic                          addr_vld,
    input logic [N_AREA:0]               cs_n,
    input logic [N_AREA-1:0]             hit,
    input logic [N_AREA-1:0][TAG_W-1:0]  base_q,
    input logic [N_AREA-1:0][TAG_W-1:0]  ign_q
);
    localparam int IGN_OFS = 2 ** (IDX_W - 1);

    logic idx_unused;
    assign idx_unused = (int'(wr_idx) >= N_AREA && int'(wr_idx) < IGN_OFS)
                     || (int'(wr_idx) >= IGN_OFS + N_AREA);

    a_r7_one_select: assert property (@(posedge clk) disable iff (rst)
        addr_vld |-> $onehot(~cs_n));

    a_r6_idle_high: assert property (@(posedge clk) disable iff (rst)
        !addr_vld |-> (&cs_n));

    a_r5_fallback: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && hit == '0) |-> !cs_n[0]);

    a_r9_unused_index: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx_unused) |=> ($stable(base_q) && $stable(ign_q)));

    a_r8_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(base_q) && $stable(ign_q)));

    for (genvar k = 0; k < N_AREA; k++) begin : g_chk
        a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
            (addr_vld && !cs_n[k+1]) |-> (hit[k] && (hit & N_AREA'((1 << k) - 1)) == '0));

        a_r1_reset_layout: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (base_q[k] == TAG_W'(k + 1) && ign_q[k] == '0));
    end
endmodule

bind csdec_top csdec_chk #(.N_AREA(N_AREA), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .addr_vld(addr_vld),
    .cs_n(cs_n), .hit(hit), .base_q(base_q), .ign_q(ign_q)
);

// File: tb/test_csdec_top.sv
module test_csdec_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [31:0] addr = '0;
    logic        addr_vld = 1'b0;
    logic [5:0]  cs_n;

    int    total = 0;
    int    bad = 0;
    bit    run = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    int    m_base [1:5];
    int    m_ign  [1:5];

    csdec_top i_csdec_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .addr(addr), .addr_vld(addr_vld), .cs_n(cs_n)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model: register state updated at the rising edge (R8, R9, R11)
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k <= 5; k++) begin
                m_base[k] = k;
                m_ign[k]  = 0;
            end
        end else if (wr_en) begin
            if (wr_idx <= 4)                    m_base[wr_idx + 1] = wr_data;
            else if (wr_idx >= 8 && wr_idx <= 12) m_ign[wr_idx - 7] = wr_data;
        end
    end

    function automatic logic [5:0] expect_cs(logic [31:0] a, logic v);
        int t;
        if (!v) return 6'h3f;
        t = a[31:16];
        for (int k = 1; k <= 5; k++)
            if ((((t ^ m_base[k]) & ~m_ign[k]) & 16'hffff) == 0) return ~(6'b1 << k);
        return 6'h3e;
    endfunction

    // Compared on every clock, a quarter period after the inputs change
    always @(negedge clk) begin
        #(CLK_P/4);
        if (run && !done) begin
            logic [5:0] e;
            e = expect_cs(addr, addr_vld);
            total++;
            if (cs_n !== e) begin
                bad++;
                $display("FAIL %s addr=%h vld=%0b actual=%b expected=%b",
                         tag, addr, addr_vld, cs_n, e);
            end
        end
    end

    task automatic put(string t, logic [31:0] a, logic v = 1'b1);
        @(negedge clk);
        tag = t; addr = a; addr_vld = v; wr_en = 1'b0;
    endtask

    task automatic wr(string t, logic [3:0] i, logic [15:0] d, logic [31:0] a);
        @(negedge clk);
        tag = t; wr_en = 1'b1; wr_idx = i; wr_data = d; addr = a; addr_vld = 1'b1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run = 1'b1;
        // R1 reset layout, R2 low bits irrelevant, R5 fallback
        for (int k = 1; k <= 5; k++) begin
            put("R1", {16'(k), 16'h0000});
            put("R2", {16'(k), 16'hffff});
        end
        put("R5", 32'h0000_1234);
        put("R5", 32'h0006_0000);
        put("R5", 32'hffff_ffff);
        // R6 strobe low
        put("R6", 32'h0001_0000, 1'b0);
        put("R6", 32'h7777_0000, 1'b0);
        // R10 address changes without a clock edge
        @(negedge clk); tag = "R10"; addr = 32'h0003_0000; addr_vld = 1'b1;
        #(CLK_P/8); addr = 32'h0004_0000; #(CLK_P/16);
        total++;
        if (cs_n !== 6'b101111) begin
            bad++; $display("FAIL R10 actual=%b expected=%b", cs_n, 6'b101111);
        end
        // R8 base write, old value before edge, R2 exact block edges
        wr("R8", 4'd0, 16'h1234, 32'h0001_0000);
        put("R8", 32'h0001_0000);
        put("R2", 32'h1234_0000);
        put("R2", 32'h1234_ffff);
        put("R2", 32'h1235_0000);
        put("R2", 32'h1233_ffff);
        // R3 ignore bits
        wr("R3", 4'd8, 16'h000f, 32'h123f_0000);
        put("R3", 32'h123f_0000);
        put("R3", 32'h1230_8000);
        put("R3", 32'h1244_0000);
        put("R3", 32'h9234_0000);
        // R4 overlap
        wr("R4", 4'd1, 16'h1234, 32'h1234_0000);
        put("R4", 32'h1234_0000);
        put("R4", 32'h0002_0000);
        wr("R4", 4'd10, 16'hffff, 32'h4444_0000);
        put("R4", 32'h4444_0000);
        put("R4", 32'h0004_0000);
        put("R4", 32'h1238_0000);
        put("R7", 32'hdead_beef);
        // R9 unused indexes
        for (int i = 5; i <= 7; i++) wr("R9", 4'(i), 16'h0004, 32'h0004_0000);
        for (int i = 13; i <= 15; i++) wr("R9", 4'(i), 16'hffff, 32'h0005_0000);
        put("R9", 32'h0004_0000);
        put("R9", 32'h0005_0000);
        // R11 reset during operation, overriding a write
        @(negedge clk); tag = "R11"; rst = 1'b1; wr_en = 1'b1; wr_idx = 4'd4; wr_data = 16'h00aa;
        @(negedge clk); rst = 1'b0; wr_en = 1'b0;
        for (int k = 1; k <= 5; k++) put("R11", {16'(k), 16'h8000});
        put("R11", 32'h1234_0000);
        put("R11", 32'h00aa_0000);
        // R4 random mix of writes and near-base addresses
        for (int n = 0; n < 400; n++) begin
            logic [15:0] hi;
            hi = 16'($urandom_range(0, 7)) ^ (($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0);
            if ($urandom_range(0, 4) == 0)
                wr("R4", 4'($urandom_range(0, 15)), 16'($urandom_range(0, 3) == 0 ? $urandom : $urandom_range(0, 7)),
                   {hi, 16'($urandom)});
            else
                put("R4", {hi, 16'($urandom)}, 1'($urandom_range(0, 7) != 0));
        end
        @(negedge clk);
        run = 1'b0;
        finish_up();
    end
endmodule